// File: doc/BRIEF.md
# Two-Tier Token-Weighted Bus Arbiter

This block decides which of four bus masters owns a shared bus. Each master raises a request line and receives a registered, one-hot grant line. A numeric grant ID is also given, where 0 means that no real master owns the bus. The grant is re-evaluated only when the `arb_point` input is high, which marks the cycle in which the current transfer ends. In all other cycles the grant holds.

Selection works on priority. Each master has a 4-bit priority, and the larger value wins. When the token scheme is on, each master also has a budget of bus cycles. A requester that still has cycles left in the current period sits in an upper tier. An upper-tier requester beats every requester that has used up its budget, and priority only orders masters within the same tier. A budget of zero places that master permanently in the upper tier. A programmable period counter reloads every budget when it expires. When nobody requests, a programmable default master can be parked on the bus.

All settings are written through a simple write-only strobe interface. Budget changes wait for the next reload boundary. Priority, default-master and enable changes are sampled at the next arbitration point.

Top module: `wtok_arbiter`

## Requirements
- R1: While and after `rst` is high, `gnt` is 0 and `gnt_id` is 0. The configuration then holds these values: priorities 15, 14, 13 and 12 for IDs 1 to 4, every budget 15, period 65535, default ID 0, and the token scheme off.
- R2: At an arbitration point with at least one request, the next cycle grants exactly one requesting master. Among the eligible masters, the one with the larger priority value wins. `gnt_id` equals the bit index plus 1, and `gnt` is one-hot on that bit.
- R3: When eligible requesters have equal priority, the lower-indexed master wins.
- R4: When `arb_point` is low, `gnt` and `gnt_id` keep their values, even if the requests change.
- R5: At an arbitration point with no request, a default ID from 1 to 4 grants that master. A default ID of 0, or one above 4, leaves `gnt` at 0 and `gnt_id` at 0.
- R6: With the scheme on, a master's token count falls by one for each cycle it holds the grant, and it stops at 0. A master whose count, after the current cycle, is still above 0 is in the upper tier. An upper-tier requester beats any lower-tier requester. With budgets B1=3 and B2=5 and both masters requesting at every point, the grants run ID 1 three times, then ID 2 five times, then ID 1.
- R7: A budget of 0 means unlimited tokens. That master never leaves the upper tier.
- R8: With the scheme on, every P cycles after it turns on, all token counts reload from the written budgets. P is the period, and a period of 0 acts as 1.
- R9: The write map is as follows. Address i (0 to 3) sets the priority of ID i+1 from `cfg_wdata[3:0]`. Address 4+i sets the budget of ID i+1. Address 8 sets the period, address 9 sets the default ID from bits [3:0], and address 10 sets the enable from bit 0. Budgets written while the scheme is on take effect at the next reload. Priority, default and enable writes take effect at the next arbitration point.
- R10: With the scheme off, budgets have no effect, and arbitration is by priority alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 4 | Request per master, bit i is ID i+1 |
| arb_point | input | 1 | Current transfer ends this cycle; the grant may change |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration address |
| cfg_wdata | input | 16 | Configuration write data |
| gnt | output | 4 | One-hot grant, registered |
| gnt_id | output | 4 | Granted ID, 0 when no real master owns the bus |

## Verification
The assertions check the following on every cycle:
- the grant vector never has more than one bit set;
- a grant made at an arbitration point goes to a master that was requesting;
- the grant is frozen between arbitration points;
- the ID and the vector agree on whether the bus is idle.

Only the bench's scenarios can show that tokens are spent one per owned cycle, that the tiers flip at the right cycle, that a zero budget is unlimited, and that reloads occur on the exact period boundary, including the period-zero case.

// File: rtl/wtok_pkg.sv
package wtok_pkg;
  localparam int RST_BUDGET   = 15;
  localparam int RST_PERIOD   = 65535;
  localparam int RST_PRIO_TOP = 15;

  function automatic int prio_reset(input int idx);
    return (idx < RST_PRIO_TOP) ? (RST_PRIO_TOP - idx) : 0;
  endfunction
endpackage

// File: rtl/wtok_cfg.sv
module wtok_cfg
  import wtok_pkg::*;
#(
  parameter int N_MST  = 4,
  parameter int PRIO_W = 4,
  parameter int TOK_W  = 16,
  parameter int ID_W   = 4,
  parameter int ADDR_W = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          we,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [TOK_W-1:0]              wdata,
  output logic [N_MST-1:0][PRIO_W-1:0]  prio,
  output logic [N_MST-1:0][TOK_W-1:0]   budget,
  output logic [TOK_W-1:0]              period,
  output logic [ID_W-1:0]               dflt_id,
  output logic                          en
);
  localparam int A_BUD  = N_MST;
  localparam int A_PER  = 2 * N_MST;
  localparam int A_DFLT = A_PER + 1;
  localparam int A_EN   = A_PER + 2;

  for (genvar i = 0; i < N_MST; i++) begin : g_mst
    always_ff @(posedge clk) begin
      if (rst) begin
        prio[i]   <= PRIO_W'(prio_reset(i));
        budget[i] <= TOK_W'(RST_BUDGET);
      end else if (we) begin
        if (addr == ADDR_W'(i))         prio[i]   <= wdata[PRIO_W-1:0];
        if (addr == ADDR_W'(A_BUD + i)) budget[i] <= wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      period  <= TOK_W'(RST_PERIOD);
      dflt_id <= '0;
      en      <= 1'b0;
    end else if (we) begin
      if (addr == ADDR_W'(A_PER))  period  <= wdata;
      if (addr == ADDR_W'(A_DFLT)) dflt_id <= wdata[ID_W-1:0];
      if (addr == ADDR_W'(A_EN))   en      <= wdata[0];
    end
  end
endmodule

// File: rtl/wtok_tokens.sv
module wtok_tokens
  import wtok_pkg::*;
#(
  parameter int N_MST = 4,
  parameter int TOK_W = 16
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        en_act,
  input  logic [N_MST-1:0]            gnt,
  input  logic [N_MST-1:0][TOK_W-1:0] bud_stg,
  input  logic [TOK_W-1:0]            per_stg,
  output logic [N_MST-1:0]            has_tok
);
  logic [TOK_W-1:0] rc;
  logic [TOK_W-1:0] per_eff;
  logic             reload;

  // a zero period behaves as a one-cycle period
  assign per_eff = (per_stg == '0) ? TOK_W'(1) : per_stg;
  // while the scheme is off, every cycle is a reload boundary
  assign reload  = !en_act || (rc == TOK_W'(1));

  always_ff @(posedge clk) begin
    if (rst)         rc <= TOK_W'(RST_PERIOD);
    else if (reload) rc <= per_eff;
    else             rc <= rc - TOK_W'(1);
  end

  for (genvar i = 0; i < N_MST; i++) begin : g_cnt
    logic [TOK_W-1:0] tok;
    logic [TOK_W-1:0] bud_act;

    always_ff @(posedge clk) begin
      if (rst) begin
        tok     <= TOK_W'(RST_BUDGET);
        bud_act <= TOK_W'(RST_BUDGET);
      end else if (reload) begin
        tok     <= bud_stg[i];
        bud_act <= bud_stg[i];
      end else if (gnt[i] && (tok != '0)) begin
        tok <= tok - TOK_W'(1);
      end
    end

    // upper tier if unlimited, or if tokens remain after this cycle's use
    assign has_tok[i] = (bud_act == '0) || (tok > TOK_W'(1)) ||
                        ((tok == TOK_W'(1)) && !gnt[i]);
  end
endmodule

// File: rtl/wtok_pick.sv
module wtok_pick #(
  parameter int N_MST  = 4,
  parameter int PRIO_W = 4
) (
  input  logic [N_MST-1:0]             req,
  input  logic [N_MST-1:0]             has_tok,
  input  logic                         en,
  input  logic [N_MST-1:0][PRIO_W-1:0] prio,
  output logic [N_MST-1:0]             win,
  output logic                         any
);
  logic [N_MST-1:0]  upper;
  logic [N_MST-1:0]  pool;
  logic [PRIO_W-1:0] best;
  logic              found;

  assign upper = en ? (req & has_tok) : '0;
  assign pool  = (|upper) ? upper : req;
  assign any   = |req;

  // strict compare keeps the lower index on equal priority
  always_comb begin
    win   = '0;
    best  = '0;
    found = 1'b0;
    for (int i = 0; i < N_MST; i++) begin
      if (pool[i] && (!found || (prio[i] > best))) begin
        win    = '0;
        win[i] = 1'b1;
        best   = prio[i];
        found  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/wtok_arbiter.sv
module wtok_arbiter #(
  parameter int N_MST  = 4,
  parameter int PRIO_W = 4,
  parameter int TOK_W  = 16,
  parameter int ID_W   = 4,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_MST-1:0]  req,
  input  logic              arb_point,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [TOK_W-1:0]  cfg_wdata,
  output logic [N_MST-1:0]  gnt,
  output logic [ID_W-1:0]   gnt_id
);
  logic [N_MST-1:0][PRIO_W-1:0] prio_stg;
  logic [N_MST-1:0][TOK_W-1:0]  bud_stg;
  logic [TOK_W-1:0]             per_stg;
  logic [ID_W-1:0]              dflt_stg;
  logic                         en_stg;
  logic                         en_act;
  logic [N_MST-1:0]             has_tok;
  logic [N_MST-1:0]             win;
  logic                         any_req;
  logic [ID_W-1:0]              win_id;
  logic [N_MST-1:0]             dflt_vec;

  wtok_cfg #(
    .N_MST(N_MST), .PRIO_W(PRIO_W), .TOK_W(TOK_W), .ID_W(ID_W), .ADDR_W(ADDR_W)
  ) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .prio(prio_stg), .budget(bud_stg), .period(per_stg),
    .dflt_id(dflt_stg), .en(en_stg)
  );

  wtok_tokens #(.N_MST(N_MST), .TOK_W(TOK_W)) u_tok (
    .clk(clk), .rst(rst), .en_act(en_act), .gnt(gnt),
    .bud_stg(bud_stg), .per_stg(per_stg), .has_tok(has_tok)
  );

  wtok_pick #(.N_MST(N_MST), .PRIO_W(PRIO_W)) u_pick (
    .req(req), .has_tok(has_tok), .en(en_stg), .prio(prio_stg),
    .win(win), .any(any_req)
  );

  always_comb begin
    win_id = '0;
    for (int i = 0; i < N_MST; i++)
      if (win[i]) win_id = ID_W'(i + 1);
  end

  for (genvar i = 0; i < N_MST; i++) begin : g_dflt
    assign dflt_vec[i] = (dflt_stg == ID_W'(i + 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt    <= '0;
      gnt_id <= '0;
      en_act <= 1'b0;
    end else if (arb_point) begin
      en_act <= en_stg;
      if (any_req) begin
        gnt    <= win;
        gnt_id <= win_id;
      end else if (|dflt_vec) begin
        gnt    <= dflt_vec;
        gnt_id <= dflt_stg;
      end else begin
        gnt    <= '0;
        gnt_id <= '0;
      end
    end
  end
endmodule

// File: rtl/wtok_arbiter_chk.sv
module wtok_arbiter_chk #(
  parameter int N_MST = 4,
  parameter int ID_W  = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [N_MST-1:0] req,
  input logic             arb_point,
  input logic [N_MST-1:0] gnt,
  input logic [ID_W-1:0]  gnt_id
);
  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (gnt == '0 && gnt_id == '0)); // R1
  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (rst) $onehot0(gnt)); // R2
  AST_GNT_TO_REQUESTER: assert property (@(posedge clk) disable iff (rst) (arb_point && (|req)) |=> (|(gnt & $past(req)))); // R2
  AST_HOLD_OFF_POINT: assert property (@(posedge clk) disable iff (rst) !arb_point |=> ($stable(gnt) && $stable(gnt_id))); // R4
  AST_IDLE_AGREES: assert property (@(posedge clk) disable iff (rst) ((gnt_id == '0) == (gnt == '0))); // R5
endmodule

bind wtok_arbiter wtok_arbiter_chk #(.N_MST(N_MST), .ID_W(ID_W)) u_chk (
  .clk(clk), .rst(rst), .req(req), .arb_point(arb_point), .gnt(gnt), .gnt_id(gnt_id)
);

// File: tb/wtok_arbiter_test.sv
module wtok_arbiter_test;
  localparam int CLK_P = 10;

  typedef struct packed {
    logic [3:0] req;
    logic [3:0] id;
  } vec_t;

  // default priorities 15,14,13,12 for IDs 1..4, scheme off (R2)
  localparam vec_t VECS [7] = '{
    '{req: 4'b0001, id: 4'd1},
    '{req: 4'b0010, id: 4'd2},
    '{req: 4'b1100, id: 4'd3},
    '{req: 4'b1000, id: 4'd4},
    '{req: 4'b1111, id: 4'd1},
    '{req: 4'b0110, id: 4'd2},
    '{req: 4'b0000, id: 4'd0}
  };

  localparam logic [3:0] SEQ_TOK [11] = '{4'd1,4'd1,4'd1,4'd2,4'd2,4'd2,4'd2,4'd2,4'd1,4'd1,4'd1};
  localparam logic [3:0] SEQ_UNL [9]  = '{4'd1,4'd1,4'd2,4'd2,4'd2,4'd2,4'd2,4'd2,4'd2};
  localparam logic [3:0] SEQ_REF [13] = '{4'd1,4'd1,4'd2,4'd2,4'd2,4'd2,4'd2,4'd2,4'd2,4'd1,4'd1,4'd1,4'd2};
  localparam logic [3:0] SEQ_P0  [6]  = '{4'd1,4'd2,4'd1,4'd2,4'd1,4'd2};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  req = '0;
  logic        arb_point = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic [3:0]  gnt;
  logic [3:0]  gnt_id;
  int          n_chk = 0;
  int          n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  wtok_arbiter uut (
    .clk(clk), .rst(rst), .req(req), .arb_point(arb_point),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .gnt(gnt), .gnt_id(gnt_id)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [3:0] exp_id);
    logic [3:0] exp_g;
    exp_g = (exp_id == 0) ? 4'b0000 : (4'b0001 << (exp_id - 1));
    n_chk++;
    if (gnt_id !== exp_id || gnt !== exp_g) begin
      n_bad++;
      $display("FAIL %s: gnt_id=%0d gnt=%b, expected gnt_id=%0d gnt=%b",
               tag, gnt_id, gnt, exp_id, exp_g);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic arb_once(input logic [3:0] r);
    req = r; arb_point = 1'b1;
    step();
    arb_point = 1'b0;
  endtask

  // scheme off, park idle
  task automatic quiesce();
    wr(4'd10, 16'd0);
    arb_once(4'b0000);
    chk("R5 idle after disable", 4'd0);
  endtask

  initial begin
    step(); step();
    chk("R1 during reset", 4'd0);
    rst = 1'b0;
    step();
    chk("R1 after reset", 4'd0);

    foreach (VECS[k]) begin
      arb_once(VECS[k].req);
      chk("R2 vector", VECS[k].id);
    end

    // R4: hold between arbitration points
    arb_once(4'b0001);
    chk("R4 setup", 4'd1);
    req = 4'b0010;
    wr(4'd1, 16'd15);
    step();
    chk("R4 hold with new request and priority write", 4'd1);
    arb_once(4'b0011);
    chk("R3 equal priority lower index", 4'd1);

    // R3: ties between masters 3 and 4
    wr(4'd0, 16'd0); wr(4'd1, 16'd0); wr(4'd2, 16'd15); wr(4'd3, 16'd15);
    arb_once(4'b1100);
    chk("R3 tie IDs 3 and 4", 4'd3);
    arb_once(4'b1010);
    chk("R2 priority ID4 over ID2", 4'd4);

    // R5: default master
    wr(4'd9, 16'd3);
    arb_once(4'b0000);
    chk("R5 default ID 3", 4'd3);
    wr(4'd9, 16'd4);
    arb_once(4'b0000);
    chk("R5 default ID 4", 4'd4);
    wr(4'd9, 16'd9);
    arb_once(4'b0000);
    chk("R5 out-of-range default", 4'd0);
    wr(4'd9, 16'd0);

    // restore priorities
    wr(4'd0, 16'd15); wr(4'd1, 16'd14); wr(4'd2, 16'd13); wr(4'd3, 16'd12);

    // R10: budgets ignored with scheme off
    wr(4'd4, 16'd1);
    req = 4'b0011; arb_point = 1'b1;
    for (int k = 0; k < 5; k++) begin
      step();
      chk("R10 scheme off ignores budget", 4'd1);
    end
    arb_point = 1'b0;
    quiesce();

    // R6: tiering with budgets 3 and 5
    wr(4'd4, 16'd3); wr(4'd5, 16'd5); wr(4'd8, 16'd1000); wr(4'd10, 16'd1);
    req = 4'b0011; arb_point = 1'b1;
    foreach (SEQ_TOK[k]) begin
      step();
      chk("R6 token tiers", SEQ_TOK[k]);
    end
    arb_point = 1'b0;
    quiesce();

    // R7: zero budget is unlimited
    wr(4'd4, 16'd2); wr(4'd5, 16'd0); wr(4'd10, 16'd1);
    req = 4'b0011; arb_point = 1'b1;
    foreach (SEQ_UNL[k]) begin
      step();
      chk("R7 unlimited budget", SEQ_UNL[k]);
    end
    arb_point = 1'b0;
    quiesce();

    // R8 period 8 reload; R9 budget written mid-period used at reload
    wr(4'd4, 16'd2); wr(4'd5, 16'd0); wr(4'd8, 16'd8); wr(4'd10, 16'd1);
    req = 4'b0011; arb_point = 1'b1;
    foreach (SEQ_REF[k]) begin
      if (k == 3) begin
        cfg_we = 1'b1; cfg_addr = 4'd4; cfg_wdata = 16'd3;
      end
      step();
      cfg_we = 1'b0;
      chk("R8 R9 refresh boundary", SEQ_REF[k]);
    end
    arb_point = 1'b0;
    quiesce();

    // R8: period zero behaves as one
    wr(4'd4, 16'd1); wr(4'd5, 16'd1); wr(4'd8, 16'd0); wr(4'd10, 16'd1);
    req = 4'b0011; arb_point = 1'b1;
    foreach (SEQ_P0[k]) begin
      step();
      chk("R8 zero period", SEQ_P0[k]);
    end
    arb_point = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_P * 50000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule